// File: doc/BRIEF.md
# Nine-bit multiprocessor UART

This block is a full-duplex asynchronous serial port. Each frame it sends or receives is eleven bit times long: a low start bit, eight data bits with the least significant bit first, a ninth data bit chosen by software, and a high stop bit. Software sets the ninth transmit bit to carry a parity value or an address/data marker. A write strobe with a byte starts a transmission. The line idles high.

The receiver waits for a falling edge on the line. It oversamples every bit against an external tick that runs at sixteen times the bit rate, and it takes a majority vote of three samples near mid-bit. If the start bit has returned high by mid-bit, the receiver drops the event as a glitch. A finished frame is stored only if reception is enabled and the receive-full flag is clear. In multiprocessor mode the received ninth bit must also be one, so a node on a shared bus can sleep through data frames and wake only on address frames. Software clears the transmit-done and receive-full flags. One interrupt request line reflects both flags.

Top module: `mp_uart9`

## Requirements
- R1: After reset, txd is 1, tx_done, rx_full and irq are 0, and rx_byte and rx_bit9 are 0.
- R2: A tx_wr pulse while the transmitter is idle sends a low start bit, then tx_byte bit 0 through bit 7, then the tx_bit9 value sampled at the write, then a high stop bit. Each bit lasts 16 tick pulses.
- R3: tx_done goes to 1 when the stop bit begins, so it is 0 while the ninth bit is on the line and 1 during the stop bit.
- R4: A tx_wr pulse while a frame is being sent is ignored. The frame in flight is not changed, and txd stays high after its stop bit.
- R5: With rx_en at 1, a received frame sets rx_full, and its eight data bits (first received bit in bit 0) go to rx_byte and its ninth bit goes to rx_bit9.
- R6: A frame that completes while rx_full is 1 is discarded, and rx_byte and rx_bit9 keep their values.
- R7: With mp_mode at 1, a frame whose ninth bit is 0 is discarded and rx_full stays 0. A frame whose ninth bit is 1 is accepted.
- R8: The value of the received stop bit is not checked. A frame with a low stop bit is still accepted.
- R9: With rx_en at 0, no frame is received and rx_full stays 0.
- R10: A low pulse on rxd that is back high before mid-bit of the start bit does not produce a frame, and a real frame that follows it is received correctly.
- R11: irq is 1 in the cycle after irq_en is 1 and either tx_done or rx_full is 1. irq is 0 in the cycle after irq_en is 0.
- R12: A tx_done_clr pulse clears tx_done, and an rx_full_clr pulse clears rx_full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | One-cycle pulse at sixteen times the bit rate |
| tx_wr | input | 1 | Write strobe that starts a transmission |
| tx_byte | input | 8 | Byte to transmit |
| tx_bit9 | input | 1 | Ninth bit to transmit |
| rx_en | input | 1 | Receive enable |
| mp_mode | input | 1 | Multiprocessor mode: accept only frames whose ninth bit is 1 |
| irq_en | input | 1 | Interrupt enable |
| tx_done_clr | input | 1 | Clears the transmit-done flag |
| rx_full_clr | input | 1 | Clears the receive-full flag |
| rxd | input | 1 | Serial receive line |
| txd | output | 1 | Serial transmit line, high when idle |
| rx_byte | output | 8 | Last accepted data byte |
| rx_bit9 | output | 1 | Ninth bit of the last accepted frame |
| tx_done | output | 1 | Transmit-done flag |
| rx_full | output | 1 | Receive-full flag |
| irq | output | 1 | Interrupt request |

## Verification
The assertions take for granted that rx_en, mp_mode and irq_en are plain levels seen each cycle. They also assume the cycle in which the receiver makes its accept decision is the cycle just before rx_full rises, so the past value of each mode input is the value that governed the decision. The bench changes rx_en and mp_mode only while the line is idle between frames. It drives rxd with bit times of exactly sixteen tick pulses, so every oversampling window falls well inside a bit. Clear strobes and write strobes are one cycle wide, and the bench applies them away from the clock edge.

// File: rtl/mp_uart9_pkg.sv
package mp_uart9_pkg;

  typedef enum logic [1:0] {
    TX_IDLE,
    TX_START,
    TX_DATA,
    TX_STOP
  } tx_state_e;

  typedef enum logic [1:0] {
    RX_IDLE,
    RX_START,
    RX_DATA,
    RX_STOP
  } rx_state_e;

  // two-of-three vote on line samples
  function automatic logic vote3(input logic a, input logic b, input logic c);
    return (a & b) | (a & c) | (b & c);
  endfunction

endpackage

// File: rtl/mp_uart9_tx.sv
module mp_uart9_tx
  import mp_uart9_pkg::*;
#(
  parameter int OVS    = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              wr,
  input  logic [DATA_W-1:0] data,
  input  logic              bit9,
  output logic              txd,
  output logic              done_set
);
  localparam int NB = DATA_W + 1;
  localparam int CW = $clog2(OVS);
  localparam int IW = $clog2(NB);

  tx_state_e         st;
  logic [CW-1:0]     cnt;
  logic [IW-1:0]     idx;
  logic [NB-1:0]     sh;
  logic              bit_end;

  assign bit_end = tick && (cnt == CW'(OVS - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= TX_IDLE;
      txd      <= 1'b1;
      cnt      <= '0;
      idx      <= '0;
      sh       <= '0;
      done_set <= 1'b0;
    end else begin
      done_set <= 1'b0;
      if (tick && st != TX_IDLE) cnt <= bit_end ? '0 : cnt + 1'b1;
      case (st)
        TX_IDLE: begin
          txd <= 1'b1;
          if (wr) begin
            sh  <= {bit9, data};
            st  <= TX_START;
            txd <= 1'b0;
            cnt <= '0;
          end
        end
        TX_START: begin
          if (bit_end) begin
            st  <= TX_DATA;
            idx <= '0;
            txd <= sh[0];
          end
        end
        TX_DATA: begin
          if (bit_end) begin
            if (idx == IW'(NB - 1)) begin
              st       <= TX_STOP;
              txd      <= 1'b1;
              done_set <= 1'b1;
            end else begin
              idx <= idx + 1'b1;
              sh  <= sh >> 1;
              txd <= sh[1];
            end
          end
        end
        TX_STOP: begin
          txd <= 1'b1;
          if (bit_end) st <= TX_IDLE;
        end
        default: st <= TX_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/mp_uart9_rx.sv
module mp_uart9_rx
  import mp_uart9_pkg::*;
#(
  parameter int OVS    = 16,
  parameter int DATA_W = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                tick,
  input  logic                en,
  input  logic                rxd,
  output logic                got,
  output logic [DATA_W:0]     word
);
  localparam int NB  = DATA_W + 1;
  localparam int CW  = $clog2(OVS);
  localparam int IW  = $clog2(NB);
  localparam int MID = OVS / 2;

  rx_state_e     st;
  logic [CW-1:0] cnt;
  logic [IW-1:0] idx;
  logic [NB-1:0] sh;
  logic          sync1, sync2, prev;
  logic          s0, s1;
  logic          v;

  assign v    = vote3(s0, s1, sync2);
  assign word = sh;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync1 <= 1'b1;
      sync2 <= 1'b1;
      prev  <= 1'b1;
    end else begin
      sync1 <= rxd;
      sync2 <= sync1;
      prev  <= sync2;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st  <= RX_IDLE;
      cnt <= '0;
      idx <= '0;
      sh  <= '0;
      s0  <= 1'b1;
      s1  <= 1'b1;
      got <= 1'b0;
    end else begin
      got <= 1'b0;
      if (st == RX_IDLE) begin
        if (en && prev && !sync2) begin
          st  <= RX_START;
          cnt <= '0;
        end
      end else if (tick) begin
        cnt <= (cnt == CW'(OVS - 1)) ? '0 : cnt + 1'b1;
        if (cnt == CW'(MID - 1)) s0 <= sync2;
        if (cnt == CW'(MID))     s1 <= sync2;
        if (cnt == CW'(MID + 1)) begin
          case (st)
            RX_START: if (v) st <= RX_IDLE;
            RX_DATA:  sh <= {v, sh[NB-1:1]};
            RX_STOP: begin
              st  <= RX_IDLE;
              got <= 1'b1;
            end
            default: st <= RX_IDLE;
          endcase
        end
        if (cnt == CW'(OVS - 1)) begin
          if (st == RX_START) begin
            st  <= RX_DATA;
            idx <= '0;
          end else if (st == RX_DATA) begin
            if (idx == IW'(NB - 1)) st <= RX_STOP;
            else idx <= idx + 1'b1;
          end
        end
      end
    end
  end

endmodule

// File: rtl/mp_uart9.sv
module mp_uart9
  import mp_uart9_pkg::*;
#(
  parameter int OVS    = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              tx_wr,
  input  logic [DATA_W-1:0] tx_byte,
  input  logic              tx_bit9,
  input  logic              rx_en,
  input  logic              mp_mode,
  input  logic              irq_en,
  input  logic              tx_done_clr,
  input  logic              rx_full_clr,
  input  logic              rxd,
  output logic              txd,
  output logic [DATA_W-1:0] rx_byte,
  output logic              rx_bit9,
  output logic              tx_done,
  output logic              rx_full,
  output logic              irq
);
  logic            tx_set;
  logic            rx_got;
  logic [DATA_W:0] rx_word;
  logic            accept;

  mp_uart9_tx #(.OVS(OVS), .DATA_W(DATA_W)) tx_i (
    .clk      (clk),
    .rst      (rst),
    .tick     (tick),
    .wr       (tx_wr),
    .data     (tx_byte),
    .bit9     (tx_bit9),
    .txd      (txd),
    .done_set (tx_set)
  );

  mp_uart9_rx #(.OVS(OVS), .DATA_W(DATA_W)) rx_i (
    .clk  (clk),
    .rst  (rst),
    .tick (tick),
    .en   (rx_en),
    .rxd  (rxd),
    .got  (rx_got),
    .word (rx_word)
  );

  // frame filter: slot free, receiver on, and address marker in mp mode
  assign accept = rx_got && rx_en && !rx_full && (!mp_mode || rx_word[DATA_W]);

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_byte <= '0;
      rx_bit9 <= 1'b0;
      rx_full <= 1'b0;
      tx_done <= 1'b0;
      irq     <= 1'b0;
    end else begin
      if (accept) begin
        rx_byte <= rx_word[DATA_W-1:0];
        rx_bit9 <= rx_word[DATA_W];
      end
      if (accept)           rx_full <= 1'b1;
      else if (rx_full_clr) rx_full <= 1'b0;
      if (tx_set)           tx_done <= 1'b1;
      else if (tx_done_clr) tx_done <= 1'b0;
      irq <= irq_en && (tx_done || rx_full);
    end
  end

endmodule

// File: rtl/mp_uart9_chk.sv
module mp_uart9_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              rx_en,
  input logic              mp_mode,
  input logic              irq_en,
  input logic              txd,
  input logic [DATA_W-1:0] rx_byte,
  input logic              rx_bit9,
  input logic              tx_done,
  input logic              rx_full,
  input logic              irq
);

  // R3
  stop_level_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(tx_done) |-> txd);

  // R6
  full_hold_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rx_full) |-> ($stable(rx_byte) && $stable(rx_bit9)));

  // R7
  mp_addr_chk: assert property (@(posedge clk) disable iff (rst)
    ($rose(rx_full) && $past(mp_mode)) |-> rx_bit9);

  // R9
  rx_enable_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(rx_full) |-> $past(rx_en));

  // R11
  irq_off_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(irq_en) |-> !irq);

  // R11
  irq_on_chk: assert property (@(posedge clk) disable iff (rst)
    $past(irq_en && (tx_done || rx_full)) |-> irq);

endmodule

bind mp_uart9 mp_uart9_chk #(.DATA_W(DATA_W)) chk_i (
  .clk     (clk),
  .rst     (rst),
  .rx_en   (rx_en),
  .mp_mode (mp_mode),
  .irq_en  (irq_en),
  .txd     (txd),
  .rx_byte (rx_byte),
  .rx_bit9 (rx_bit9),
  .tx_done (tx_done),
  .rx_full (rx_full),
  .irq     (irq)
);

// File: tb/mp_uart9_tb_top.sv
module mp_uart9_tb_top;
  localparam int OVS = 16;
  localparam int DIV = 2;
  localparam int BIT = OVS * DIV;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick = 1'b0;
  logic       tx_wr = 1'b0;
  logic [7:0] tx_byte = '0;
  logic       tx_bit9 = 1'b0;
  logic       rx_en = 1'b0;
  logic       mp_mode = 1'b0;
  logic       irq_en = 1'b0;
  logic       tx_done_clr = 1'b0;
  logic       rx_full_clr = 1'b0;
  logic       rxd = 1'b1;
  logic       txd;
  logic [7:0] rx_byte;
  logic       rx_bit9;
  logic       tx_done;
  logic       rx_full;
  logic       irq;

  int checks = 0;
  int fails  = 0;
  int tdiv   = 0;

  always #10 clk = ~clk;

  always @(negedge clk) begin
    tdiv <= (tdiv == DIV - 1) ? 0 : tdiv + 1;
    tick <= (tdiv == DIV - 1);
  end

  mp_uart9 #(.OVS(OVS), .DATA_W(8)) dut_i (
    .clk(clk), .rst(rst), .tick(tick), .tx_wr(tx_wr), .tx_byte(tx_byte),
    .tx_bit9(tx_bit9), .rx_en(rx_en), .mp_mode(mp_mode), .irq_en(irq_en),
    .tx_done_clr(tx_done_clr), .rx_full_clr(rx_full_clr), .rxd(rxd),
    .txd(txd), .rx_byte(rx_byte), .rx_bit9(rx_bit9), .tx_done(tx_done),
    .rx_full(rx_full), .irq(irq)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_clr(input bit txc, input bit rxc);
    tx_done_clr = txc;
    rx_full_clr = rxc;
    wait_n(1);
    tx_done_clr = 1'b0;
    rx_full_clr = 1'b0;
    wait_n(1);
  endtask

  task automatic t_reset;
    chk(txd == 1'b1, "R1 txd", int'(txd), 1);
    chk(!tx_done && !rx_full && !irq, "R1 flags", int'({tx_done, rx_full, irq}), 0);
    chk(rx_byte == 8'h00 && !rx_bit9, "R1 rx regs", int'({rx_bit9, rx_byte}), 0);
  endtask

  // sends a frame and observes txd at each mid-bit; optional write while busy
  task automatic t_tx(input logic [7:0] d, input logic b9, input bit poke);
    logic [8:0] got;
    tx_byte = d;
    tx_bit9 = b9;
    tx_wr   = 1'b1;
    wait_n(1);
    tx_wr   = 1'b0;
    wait_n(BIT / 2 - 1);
    chk(txd == 1'b0, "R2 start bit", int'(txd), 0);
    for (int i = 0; i < 9; i++) begin
      wait_n(BIT);
      got[i] = txd;
      if (poke && i == 3) begin
        tx_byte = ~d;
        tx_bit9 = ~b9;
        tx_wr   = 1'b1;
        wait_n(1);
        tx_wr   = 1'b0;
        wait_n(BIT - 1);
        got[i + 1] = txd;
        i++;
      end
    end
    chk(tx_done == 1'b0, "R3 done low in ninth bit", int'(tx_done), 0);
    chk(got == {b9, d}, poke ? "R4 frame kept" : "R2 payload", int'(got), int'({b9, d}));
    wait_n(BIT);
    chk(txd == 1'b1, "R2 stop bit", int'(txd), 1);
    chk(tx_done == 1'b1, "R3 done in stop bit", int'(tx_done), 1);
    if (poke) begin
      int lows = 0;
      wait_n(BIT / 2 + 4);
      for (int k = 0; k < 3 * BIT; k++) begin
        wait_n(1);
        if (!txd) lows++;
      end
      chk(lows == 0, "R4 no second frame", lows, 0);
    end else begin
      wait_n(BIT);
    end
  endtask

  task automatic t_tx_flags;
    irq_en = 1'b0;
    wait_n(2);
    chk(irq == 1'b0, "R11 irq masked", int'(irq), 0);
    irq_en = 1'b1;
    wait_n(2);
    chk(irq == 1'b1, "R11 irq from tx_done", int'(irq), 1);
    pulse_clr(1'b1, 1'b0);
    chk(tx_done == 1'b0, "R12 tx_done cleared", int'(tx_done), 0);
    wait_n(1);
    chk(irq == 1'b0, "R11 irq drops", int'(irq), 0);
    irq_en = 1'b0;
  endtask

  task automatic send(input logic [7:0] d, input logic b9, input logic stp);
    logic [10:0] f;
    f = {stp, b9, d, 1'b0};
    for (int i = 0; i < 11; i++) begin
      rxd = f[i];
      wait_n(BIT);
    end
    rxd = 1'b1;
    wait_n(BIT);
  endtask

  task automatic t_rx_basic;
    rx_en = 1'b1;
    send(8'hA5, 1'b0, 1'b1);
    chk(rx_full == 1'b1, "R5 full set", int'(rx_full), 1);
    chk(rx_byte == 8'hA5 && !rx_bit9, "R5 data", int'({rx_bit9, rx_byte}), 'h0A5);
    irq_en = 1'b1;
    wait_n(2);
    chk(irq == 1'b1, "R11 irq from rx_full", int'(irq), 1);
    irq_en = 1'b0;
  endtask

  task automatic t_rx_overrun;
    send(8'h3C, 1'b1, 1'b1);
    chk(rx_byte == 8'hA5 && !rx_bit9, "R6 regs kept", int'({rx_bit9, rx_byte}), 'h0A5);
    chk(rx_full == 1'b1, "R6 full stays", int'(rx_full), 1);
    pulse_clr(1'b0, 1'b1);
    chk(rx_full == 1'b0, "R12 rx_full cleared", int'(rx_full), 0);
  endtask

  task automatic t_rx_mp;
    mp_mode = 1'b1;
    wait_n(2);
    send(8'h77, 1'b0, 1'b1);
    chk(rx_full == 1'b0, "R7 data frame dropped", int'(rx_full), 0);
    chk(rx_byte == 8'hA5, "R7 regs kept", int'(rx_byte), 'hA5);
    send(8'h42, 1'b1, 1'b1);
    chk(rx_full == 1'b1 && rx_byte == 8'h42 && rx_bit9,
        "R7 address accepted", int'({rx_full, rx_bit9, rx_byte}), 'h342);
    pulse_clr(1'b0, 1'b1);
    mp_mode = 1'b0;
    wait_n(2);
  endtask

  task automatic t_rx_stop0;
    send(8'h19, 1'b1, 1'b0);
    chk(rx_full == 1'b1 && rx_byte == 8'h19, "R8 low stop accepted",
        int'({rx_full, rx_byte}), 'h119);
    pulse_clr(1'b0, 1'b1);
  endtask

  task automatic t_rx_off;
    rx_en = 1'b0;
    wait_n(2);
    send(8'h66, 1'b0, 1'b1);
    chk(rx_full == 1'b0, "R9 disabled no frame", int'(rx_full), 0);
    chk(rx_byte == 8'h19, "R9 regs kept", int'(rx_byte), 'h19);
    rx_en = 1'b1;
    wait_n(4);
  endtask

  task automatic t_rx_glitch;
    rxd = 1'b0;
    wait_n(6);
    rxd = 1'b1;
    wait_n(2 * BIT);
    chk(rx_full == 1'b0, "R10 glitch dropped", int'(rx_full), 0);
    send(8'hC3, 1'b0, 1'b1);
    chk(rx_full == 1'b1 && rx_byte == 8'hC3, "R10 frame after glitch",
        int'({rx_full, rx_byte}), 'h1C3);
    pulse_clr(1'b0, 1'b1);
  endtask

  task automatic finish_run;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
    finish_run();
  end

  initial begin
    wait_n(4);
    rst = 1'b0;
    wait_n(2);
    t_reset();
    t_tx(8'h5A, 1'b1, 1'b0);
    t_tx_flags();
    t_tx(8'h81, 1'b0, 1'b1);
    pulse_clr(1'b1, 1'b0);
    t_rx_basic();
    t_rx_overrun();
    t_rx_mp();
    t_rx_stop0();
    t_rx_off();
    t_rx_glitch();
    finish_run();
  end

endmodule